// File: doc/BRIEF.md
# Shared-Bus Four-Phase Adder

This block adds two words that reach it one after the other over a single shared bus, and it returns the sum on that same bus. A two-bit phase counter runs without stopping and steps through a fixed four-cycle schedule: capture the first operand, capture the second operand, add, then drive the result. The bus source gets no handshake. It must place the first operand on the bus in phase 0 and the second in phase 1, and it must release the bus in phase 3, when the block drives it.

The adder is a ripple chain built from per-bit propagate and generate terms. It must settle within the single add cycle, because the result register captures its output at the end of that cycle. The sum wraps at the data width, and the carry out of the top bit is dropped. The three operand and result registers are visible as outputs. A one-cycle strobe marks the phase in which the result is on the bus.

Top module: `busadd_datapath`

## Requirements
- R1: A synchronous active-high reset clears reg_a, reg_b and reg_c to zero and returns the schedule to phase 0. The first cycle after reset is released is phase 0.
- R2: reg_a takes bus_in at the clock edge that ends phase 0 and holds its value at every other edge.
- R3: reg_b takes bus_in at the clock edge that ends phase 1 and holds its value at every other edge.
- R4: reg_c takes the adder output at the clock edge that ends phase 2 and holds its value at every other edge.
- R5: The adder output is (reg_a + reg_b) modulo 2^W. The carry out of bit W-1 is discarded, so for example 8'hFF + 8'h01 gives 8'h00.
- R6: bus_oe is 1 only in phase 3, and bus_out then equals reg_c. In phases 0 to 2, bus_oe is 0 and bus_out is all zeros.
- R7: res_valid is 1 in phase 3 only, for exactly one cycle of every four.
- R8: The schedule advances one phase per clock, going 0, 1, 2, 3 and back to 0, and repeats every four cycles until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | W | Word sampled from the shared bus |
| bus_out | output | W | Result word driven to the bus in phase 3, zero otherwise |
| bus_oe | output | 1 | Bus drive enable, high in phase 3 |
| reg_a | output | W | First-operand register |
| reg_b | output | W | Second-operand register |
| reg_c | output | W | Result register |
| res_valid | output | 1 | One-cycle strobe that marks the result phase |

## Verification
Operand pairs come in four kinds, and each kind exposes a different class of fault:
- Zero pairs and small pairs separate a working adder from one that is stuck.
- Pairs such as FF+01 and FF+FF carry through every bit and wrap, so they catch a broken carry chain and any leak of the final carry.
- Alternating patterns such as 55+AA produce no carries at all, so a propagate term that is wrongly used as a generate term stands out.

While the operands are captured, the bench puts unrelated junk on the bus in the other phases. Any load that fires in the wrong phase then shows up as a register value that differs from the intended operand. A reset raised in the middle of the schedule checks that the next round starts cleanly in phase 0.

// File: rtl/busadd_pkg.sv
package busadd_pkg;

    typedef enum logic [1:0] {
        PH_TAKE_A = 2'd0,
        PH_TAKE_B = 2'd1,
        PH_ADD    = 2'd2,
        PH_DRIVE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic ld_a;
        logic ld_b;
        logic ld_c;
        logic drive;
    } ctrl_t;

    function automatic ctrl_t decode_phase(input phase_e ph);
        ctrl_t c;
        c.ld_a  = (ph == PH_TAKE_A);
        c.ld_b  = (ph == PH_TAKE_B);
        c.ld_c  = (ph == PH_ADD);
        c.drive = (ph == PH_DRIVE);
        return c;
    endfunction

    function automatic logic pg_sum(input logic p, input logic cin);
        return p ^ cin;
    endfunction

    function automatic logic pg_carry(input logic g, input logic p, input logic cin);
        return g | (p & cin);
    endfunction

endpackage

// File: rtl/busadd_phase_ctrl.sv
module busadd_phase_ctrl
    import busadd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output ctrl_t ctrl
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_TAKE_A;
        else     phase_q <= phase_e'(phase_q + 2'd1);
    end

    always_comb ctrl = decode_phase(phase_q);
endmodule

// File: rtl/busadd_ld_reg.sv
module busadd_ld_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/busadd_pg_adder.sv
module busadd_pg_adder
    import busadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] cin;

    assign cin[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p    = a[i] ^ b[i];
        assign s[i] = pg_sum(p, cin[i]);
        if (i < W - 1) begin : g_carry
            logic g;
            assign g        = a[i] & b[i];
            assign cin[i+1] = pg_carry(g, p, cin[i]);
        end
    end
endmodule

// File: rtl/busadd_datapath.sv
module busadd_datapath
    import busadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic [W-1:0] reg_c,
    output logic         res_valid
);
    ctrl_t        ctrl;
    logic [W-1:0] sum;

    busadd_phase_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl)
    );

    busadd_ld_reg #(.W(W)) u_reg_a (
        .clk (clk), .rst (rst), .ld (ctrl.ld_a), .d (bus_in), .q (reg_a)
    );

    busadd_ld_reg #(.W(W)) u_reg_b (
        .clk (clk), .rst (rst), .ld (ctrl.ld_b), .d (bus_in), .q (reg_b)
    );

    busadd_pg_adder #(.W(W)) u_add (
        .a (reg_a), .b (reg_b), .s (sum)
    );

    busadd_ld_reg #(.W(W)) u_reg_c (
        .clk (clk), .rst (rst), .ld (ctrl.ld_c), .d (sum), .q (reg_c)
    );

    assign bus_oe    = ctrl.drive;
    assign res_valid = ctrl.drive;
    assign bus_out   = ctrl.drive ? reg_c : '0;
endmodule

// File: rtl/busadd_datapath_chk.sv
module busadd_datapath_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] reg_b,
    input logic [W-1:0] reg_c,
    input logic         res_valid
);
    logic [1:0]   ph;
    logic [W-1:0] want_sum;

    always_ff @(posedge clk) begin
        if (rst) ph <= 2'd0;
        else     ph <= ph + 2'd1;
    end

    always_comb want_sum = W'(reg_a + reg_b);

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_a == '0 && reg_b == '0 && reg_c == '0 && !bus_oe));
    // R2
    p_a_load_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == 2'd0) |=> (reg_a == $past(bus_in)));
    p_a_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ph != 2'd0) |=> $stable(reg_a));
    // R3
    p_b_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ph == 2'd1) |=> (reg_b == $past(bus_in)));
    p_b_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ph != 2'd1) |=> $stable(reg_b));
    // R4, R5
    p_c_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (ph == 2'd2) |=> (reg_c == $past(want_sum)));
    p_c_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ph != 2'd2) |=> $stable(reg_c));
    // R6
    p_drive_phase_r6: assert property (@(posedge clk) disable iff (rst)
        bus_oe == (ph == 2'd3));
    p_drive_data_r6: assert property (@(posedge clk) disable iff (rst)
        bus_out == (bus_oe ? reg_c : '0));
    // R7, R8
    p_strobe_once_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    p_strobe_period_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid == (ph == 2'd3));
endmodule

bind busadd_datapath busadd_datapath_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .reg_c     (reg_c),
    .res_valid (res_valid)
);

// File: tb/busadd_datapath_bench.sv
`timescale 1ns/1ps
module busadd_datapath_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out, reg_a, reg_b, reg_c;
    logic         bus_oe, res_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] prev_c = '0;

    always #2.5 clk = ~clk;

    busadd_datapath #(.W(W)) u_busadd_datapath (
        .clk (clk), .rst (rst), .bus_in (bus_in), .bus_out (bus_out),
        .bus_oe (bus_oe), .reg_a (reg_a), .reg_b (reg_b), .reg_c (reg_c),
        .res_valid (res_valid)
    );

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] full;
        full = {1'b0, a} + {1'b0, b};
        return full[W-1:0];
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Entered just after a falling edge, in phase 0.
    task automatic run_round(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s;
        s = ref_sum(a, b);
        bus_in = a;
        chk("R6 oe low in phase0", W'(bus_oe), '0);
        chk("R7 valid low in phase0", W'(res_valid), '0);
        @(negedge clk);
        chk("R2 A loaded", reg_a, a);
        chk("R4 C held", reg_c, prev_c);
        bus_in = b;
        @(negedge clk);
        chk("R3 B loaded", reg_b, b);
        chk("R2 A ignores phase1 bus", reg_a, a);
        chk("R6 oe low in phase2", W'(bus_oe), '0);
        bus_in = W'($urandom);
        @(negedge clk);
        chk("R5 sum in C", reg_c, s);
        chk("R6 bus_out drives C", bus_out, s);
        chk("R6 oe high in phase3", W'(bus_oe), W'(1));
        chk("R7 valid in phase3", W'(res_valid), W'(1));
        chk("R3 B ignores phase2 bus", reg_b, b);
        bus_in = W'($urandom);
        @(negedge clk);
        chk("R8 wrap to phase0, oe low", W'(bus_oe), '0);
        chk("R6 bus_out zero", bus_out, '0);
        chk("R2 A ignores phase3 bus", reg_a, a);
        chk("R4 C held after drive", reg_c, s);
        prev_c = s;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset A", reg_a, '0);
        chk("R1 reset B", reg_b, '0);
        chk("R1 reset C", reg_c, '0);
        chk("R1 reset oe", W'(bus_oe), '0);
        rst = 1'b0;

        run_round(8'h00, 8'h00);
        run_round(8'h03, 8'h04);
        run_round(8'hFF, 8'h01);
        run_round(8'hFF, 8'hFF);
        run_round(8'h80, 8'h80);
        run_round(8'h55, 8'hAA);

        for (int i = 0; i < 40; i++) run_round(W'($urandom), W'($urandom));

        // Reset raised in the middle of the schedule (R1).
        bus_in = 8'h12;
        @(negedge clk);
        bus_in = 8'h34;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset A", reg_a, '0);
        chk("R1 mid reset B", reg_b, '0);
        chk("R1 mid reset C", reg_c, '0);
        rst = 1'b0;
        prev_c = '0;
        run_round(8'h21, 8'h10);
        for (int i = 0; i < 8; i++) run_round(W'($urandom), W'($urandom));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule